// File: doc/BRIEF.md
# Dual-Port RAM with Address-Collision Arbitration

This block is a synchronous word memory with two symmetric, fully independent access ports, named left and right. Each port carries an enable, a read enable, one write strobe per byte lane (upper lane bits 15:8, lower lane bits 7:0), an address, write data and registered read data. Both ports may read any word in the same cycle, including the same word.

When both enabled ports point at one word, an arbiter decides which port owns it and raises a busy flag on the other port. Ownership goes to the port that was already sitting on that address in the previous cycle. The losing port keeps its busy flag until the addresses part. In master mode the busy flags are outputs, and a write from the flagged port is dropped.

In slave mode the busy flags come in from outside, normally from a master instance that shares the address buses. A port whose incoming busy is high cannot write. Several instances can then be placed side by side to build a wider word. All inputs are sampled on one clock.

Top module: `twin_port_ram`

## Requirements
- R1: On a rising edge where a port is enabled (`*_ce`=1), the write strobe `*_we_hi` writes bits 15:8 of `*_wdata` and `*_we_lo` writes bits 7:0 into the addressed word. A lane whose strobe is low keeps its old contents.
- R2: Read data is registered. It appears on `*_rdata` after the rising edge at which `*_ce`=1 and `*_oe`=1 were sampled. If the same word is written in that same cycle, the old contents are returned.
- R3: Both ports reading the same word in the same cycle both receive its contents.
- R4: After any edge at which a port had `*_ce`=0 or `*_oe`=0, that port's `*_rdata` is all zeros. Reset also clears it.
- R5: A port with `*_ce`=0 writes nothing, and while either port is disabled neither busy output is raised.
- R6: A collision means both ports are enabled with equal addresses. If it starts while one port held that same address with its enable high in the previous cycle and the other port did not, the holding port wins and the other port's busy output goes high. The winner's busy output stays low.
- R7: If a collision starts and neither port qualifies as the earlier one (for example, both arrive together), the left port wins and `r_busy_out` goes high.
- R8: The winner is kept for as long as the collision lasts without a break. Busy drops in the same cycle that the addresses differ or a port is disabled.
- R9: In master mode (`slave_mode`=0), a write from a port whose busy output is high changes nothing, and the winning port's write in that cycle completes. The `*_busy_in` inputs are ignored in this mode.
- R10: In slave mode (`slave_mode`=1), both busy outputs are held low. A write from a port whose `*_busy_in` is high changes nothing, whatever the addresses are.
- R11: In slave mode, when both ports write the same word in one cycle and neither is blocked, each lane takes the left port's byte if the left port strobes that lane, otherwise the right port's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of read registers and arbiter state |
| slave_mode | input | 1 | 0: master, busy driven out; 1: slave, busy taken in |
| l_ce | input | 1 | Left port enable |
| l_oe | input | 1 | Left port read enable |
| l_we_hi | input | 1 | Left write strobe, bits 15:8 |
| l_we_lo | input | 1 | Left write strobe, bits 7:0 |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_busy_in | input | 1 | Left write block, used in slave mode |
| l_busy_out | output | 1 | Left lost arbitration (master mode) |
| r_ce | input | 1 | Right port enable |
| r_oe | input | 1 | Right port read enable |
| r_we_hi | input | 1 | Right write strobe, bits 15:8 |
| r_we_lo | input | 1 | Right write strobe, bits 7:0 |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_busy_in | input | 1 | Right write block, used in slave mode |
| r_busy_out | output | 1 | Right lost arbitration (master mode) |

## Verification
Arbitration and writing meet in one cycle when a port arrives with a write strobe on an address the other port already holds and is also writing. The bench provokes this from each side: one port parks on a word for a cycle, then the other port moves onto it while both strobe different data. In that cycle it checks which busy flag is raised. It then reads the word back to confirm that only the holder's data landed. The slave-mode counterpart, two unblocked writes to one word with mixed lane strobes, is judged the same way against the lane-merge rule.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  typedef enum logic {
    MODE_MASTER = 1'b0,
    MODE_SLAVE  = 1'b1
  } tpr_mode_e;

  localparam int LANES = 2;
endpackage

// File: rtl/tpr_arbiter.sv
module tpr_arbiter #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_lose,
  output logic              r_lose
);
  logic              clash, clash_q;
  logic              left_owns_q, left_owns;
  logic              l_ce_q, r_ce_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  logic              l_parked, r_parked, onset;

  assign clash    = l_ce && r_ce && (l_addr == r_addr);
  assign onset    = clash && !clash_q;
  // a port is "parked" if it sat enabled on the same address last cycle
  assign l_parked = l_ce_q && (l_addr_q == l_addr);
  assign r_parked = r_ce_q && (r_addr_q == r_addr);
  // right wins only when it alone was parked; every tie goes left
  assign left_owns = onset ? (l_parked || !r_parked) : left_owns_q;

  assign l_lose = clash && !left_owns;
  assign r_lose = clash && left_owns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clash_q     <= 1'b0;
      left_owns_q <= 1'b1;
      l_ce_q      <= 1'b0;
      r_ce_q      <= 1'b0;
      l_addr_q    <= '0;
      r_addr_q    <= '0;
    end else begin
      clash_q     <= clash;
      left_owns_q <= left_owns;
      l_ce_q      <= l_ce;
      r_ce_q      <= r_ce;
      l_addr_q    <= l_addr;
      r_addr_q    <= r_addr;
    end
  end
endmodule

// File: rtl/tpr_port_gate.sv
module tpr_port_gate
  import tpr_pkg::*;
(
  input  logic             slave_mode,
  input  logic             ce,
  input  logic             oe,
  input  logic             we_hi,
  input  logic             we_lo,
  input  logic             busy_in,
  input  logic             lose,
  output logic [LANES-1:0] lane_we,
  output logic             rd_en,
  output logic             busy_out
);
  tpr_mode_e mode;
  logic      blocked;

  assign mode     = tpr_mode_e'(slave_mode);
  assign blocked  = (mode == MODE_SLAVE) ? busy_in : lose;
  assign busy_out = (mode == MODE_MASTER) && lose;
  assign rd_en    = ce && oe;
  assign lane_we  = (ce && !blocked) ? {we_hi, we_lo} : '0;
endmodule

// File: rtl/tpr_store.sv
module tpr_store
  import tpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  l_we,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic [LANES-1:0]  r_we,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] l_q, r_q;

    // right first, left last: left's byte survives a same-word write
    always_ff @(posedge clk) begin
      if (r_we[g]) cells[r_addr] <= r_wdata[g*LANE_W +: LANE_W];
      if (l_we[g]) cells[l_addr] <= l_wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        l_q <= '0;
        r_q <= '0;
      end else begin
        l_q <= l_rd ? cells[l_addr] : '0;
        r_q <= r_rd ? cells[r_addr] : '0;
      end
    end

    assign l_rdata[g*LANE_W +: LANE_W] = l_q;
    assign r_rdata[g*LANE_W +: LANE_W] = r_q;
  end
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import tpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              l_ce,
  input  logic              l_oe,
  input  logic              l_we_hi,
  input  logic              l_we_lo,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_in,
  output logic              l_busy_out,
  input  logic              r_ce,
  input  logic              r_oe,
  input  logic              r_we_hi,
  input  logic              r_we_lo,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_in,
  output logic              r_busy_out
);
  logic             l_lose, r_lose;
  logic [LANES-1:0] l_lane_we, r_lane_we;
  logic             l_rd, r_rd;

  tpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .l_ce   (l_ce),
    .l_addr (l_addr),
    .r_ce   (r_ce),
    .r_addr (r_addr),
    .l_lose (l_lose),
    .r_lose (r_lose)
  );

  tpr_port_gate u_lgate (
    .slave_mode (slave_mode),
    .ce         (l_ce),
    .oe         (l_oe),
    .we_hi      (l_we_hi),
    .we_lo      (l_we_lo),
    .busy_in    (l_busy_in),
    .lose       (l_lose),
    .lane_we    (l_lane_we),
    .rd_en      (l_rd),
    .busy_out   (l_busy_out)
  );

  tpr_port_gate u_rgate (
    .slave_mode (slave_mode),
    .ce         (r_ce),
    .oe         (r_oe),
    .we_hi      (r_we_hi),
    .we_lo      (r_we_lo),
    .busy_in    (r_busy_in),
    .lose       (r_lose),
    .lane_we    (r_lane_we),
    .rd_en      (r_rd),
    .busy_out   (r_busy_out)
  );

  tpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_we    (l_lane_we),
    .l_rd    (l_rd),
    .l_addr  (l_addr),
    .l_wdata (l_wdata),
    .l_rdata (l_rdata),
    .r_we    (r_lane_we),
    .r_rd    (r_rd),
    .r_addr  (r_addr),
    .r_wdata (r_wdata),
    .r_rdata (r_rdata)
  );
endmodule

// File: rtl/tpr_checker.sv
module tpr_checker #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_mode,
  input logic              l_ce,
  input logic              l_oe,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_busy_out,
  input logic              r_ce,
  input logic              r_oe,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_busy_out
);
  logic same;
  assign same = l_ce && r_ce && (l_addr == r_addr);

  // R6
  one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_busy_out && r_busy_out));

  // R10
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (!l_busy_out && !r_busy_out));

  // R5
  idle_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce || !r_ce) |-> (!l_busy_out && !r_busy_out));

  // R4
  l_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_ce && l_oe) |=> (l_rdata == '0));

  // R4
  r_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_ce && r_oe) |=> (r_rdata == '0));

  // R8
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_busy_out |=> (!same || slave_mode || r_busy_out));

  // R8
  l_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_busy_out |=> (!same || slave_mode || l_busy_out));

  // R7
  tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (same && !slave_mode && $past(!l_ce && !r_ce)) |-> r_busy_out);
endmodule

bind twin_port_ram tpr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_twin_port_ram.sv
module tb_twin_port_ram;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, slave = 1'b0;
  logic lce, loe, lwh, lwl, lbi, rce, roe, rwh, rwl, rbi;
  logic [AW-1:0] laddr, raddr;
  logic [DW-1:0] lwd, rwd, lrd, rrd;
  logic lbo, rbo;
  logic [DW-1:0] expm [N];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  twin_port_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave),
    .l_ce(lce), .l_oe(loe), .l_we_hi(lwh), .l_we_lo(lwl), .l_addr(laddr),
    .l_wdata(lwd), .l_rdata(lrd), .l_busy_in(lbi), .l_busy_out(lbo),
    .r_ce(rce), .r_oe(roe), .r_we_hi(rwh), .r_we_lo(rwl), .r_addr(raddr),
    .r_wdata(rwd), .r_rdata(rrd), .r_busy_in(rbi), .r_busy_out(rbo));

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return 16'((a * 16'h0123) ^ (k * 16'h1F07) ^ 16'h5A3C);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic lset(input logic ce, oe, wh, wl, input int a, input logic [DW-1:0] d);
    lce = ce; loe = oe; lwh = wh; lwl = wl; laddr = AW'(a); lwd = d;
  endtask

  task automatic rset(input logic ce, oe, wh, wl, input int a, input logic [DW-1:0] d);
    rce = ce; roe = oe; rwh = wh; rwl = wl; raddr = AW'(a); rwd = d;
  endtask

  task automatic idle();
    lset(0, 0, 0, 0, 0, '0);
    rset(0, 0, 0, 0, 0, '0);
    cyc();
  endtask

  task automatic rread(input int a, input string req);
    lset(0, 0, 0, 0, 0, '0);
    rset(1, 1, 0, 0, a, '0);
    cyc();
    check(req, rrd, expm[a]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    lbi = 0; rbi = 0;
    lset(0, 0, 0, 0, 0, '0);
    rset(0, 0, 0, 0, 0, '0);
    repeat (3) @(negedge clk);
    check("R4 reset l", lrd, '0);
    check("R4 reset r", rrd, '0);
    check("R5 reset busy", {14'd0, lbo, rbo}, '0);
    rst_n = 1'b1;
    cyc();

    // R1 full-word sweep from left, R2 read back from right
    for (int a = 0; a < N; a++) begin
      lset(1, 0, 1, 1, a, pat(a, 1));
      cyc();
      expm[a] = pat(a, 1);
    end
    for (int a = 0; a < N; a++) rread(a, "R2 sweep");

    // R1 upper lane only, from right
    lset(0, 0, 0, 0, 0, '0);
    for (int a = 0; a < N; a++) begin
      rset(1, 0, 1, 0, a, pat(a, 2));
      cyc();
      expm[a] = {pat(a, 2)[15:8], expm[a][7:0]};
    end
    rset(0, 0, 0, 0, 0, '0);
    for (int a = 0; a < N; a++) begin
      lset(1, 1, 0, 0, a, '0);
      cyc();
      check("R1 upper lane", lrd, expm[a]);
    end

    // R1 lower lane from left, R3 dual read of same word
    for (int a = 0; a < N; a++) begin
      lset(1, 0, 0, 1, a, pat(a, 3));
      cyc();
      expm[a] = {expm[a][15:8], pat(a, 3)[7:0]};
    end
    for (int a = 0; a < N; a++) begin
      lset(1, 1, 0, 0, a, '0);
      rset(1, 1, 0, 0, a, '0);
      cyc();
      check("R3 left", lrd, expm[a]);
      check("R3 right", rrd, expm[a]);
    end

    // R2 read-first on same-cycle write
    idle();
    lset(1, 1, 1, 1, 2, pat(2, 4));
    cyc();
    check("R2 old data", lrd, expm[2]);
    expm[2] = pat(2, 4);
    lset(1, 1, 0, 0, 2, '0);
    cyc();
    check("R2 new data", lrd, expm[2]);

    // R4 output zeroed
    lset(1, 0, 0, 0, 2, '0);
    cyc();
    check("R4 oe low", lrd, '0);
    lset(0, 1, 0, 0, 2, '0);
    cyc();
    check("R4 ce low", lrd, '0);

    // R5 disabled port writes nothing, no busy
    lset(1, 1, 0, 0, 6, '0);
    rset(0, 1, 1, 1, 6, 16'hDEAD);
    #1 check("R5 no busy", {14'd0, lbo, rbo}, '0);
    cyc();
    rread(6, "R5 no write");

    // R6 left parked, right arrives; R9 right write dropped, left lands
    idle();
    lset(1, 1, 0, 0, 3, '0);
    rset(1, 1, 0, 0, 5, '0);
    cyc();
    lset(1, 1, 1, 1, 3, 16'hAAAA);
    rset(1, 1, 1, 1, 3, 16'h5555);
    #1 check("R6 right busy", {14'd0, lbo, rbo}, 16'h0001);
    cyc();
    expm[3] = 16'hAAAA;
    lset(1, 1, 0, 0, 3, '0);
    rset(1, 1, 0, 0, 3, '0);
    #1 check("R8 held", {14'd0, lbo, rbo}, 16'h0001);
    cyc();
    check("R9 winner data", lrd, expm[3]);
    rset(1, 1, 0, 0, 6, '0);
    #1 check("R8 release", {14'd0, lbo, rbo}, '0);
    cyc();

    // R6 right parked, left arrives; R9 left write dropped
    idle();
    lset(1, 1, 0, 0, 1, '0);
    rset(1, 1, 0, 0, 8, '0);
    cyc();
    lset(1, 1, 1, 1, 8, 16'h1234);
    rset(1, 1, 1, 1, 8, 16'h9876);
    #1 check("R6 left busy", {14'd0, lbo, rbo}, 16'h0002);
    cyc();
    expm[8] = 16'h9876;
    idle();
    rread(8, "R9 loser dropped");

    // R7 simultaneous arrival
    idle();
    lset(1, 1, 0, 0, 7, '0);
    rset(1, 1, 0, 0, 7, '0);
    #1 check("R7 tie left wins", {14'd0, lbo, rbo}, 16'h0001);
    cyc();

    // R9 busy_in ignored in master mode
    idle();
    lbi = 1; rbi = 1;
    lset(1, 0, 1, 1, 5, pat(5, 7));
    cyc();
    expm[5] = pat(5, 7);
    rread(5, "R9 busy_in ignored");

    // R10 slave mode
    slave = 1; lbi = 0; rbi = 0;
    idle();
    lset(1, 1, 0, 0, 4, '0);
    rset(1, 1, 0, 0, 4, '0);
    #1 check("R10 busy out low", {14'd0, lbo, rbo}, '0);
    cyc();
    lbi = 1;
    lset(1, 0, 1, 1, 4, 16'hBEEF);
    rset(0, 0, 0, 0, 0, '0);
    cyc();
    rread(4, "R10 blocked write");
    rbi = 0;
    lset(1, 1, 0, 0, 4, '0);
    rset(1, 0, 1, 1, 4, 16'hC0DE);
    cyc();
    expm[4] = 16'hC0DE;
    lbi = 0;
    rread(4, "R10 unblocked write");

    // R11 same-word writes, left upper only, right both lanes
    idle();
    lset(1, 0, 1, 0, 9, 16'hA1B2);
    rset(1, 0, 1, 1, 9, 16'hC3D4);
    cyc();
    expm[9] = 16'hA1D4;
    rread(9, "R11 lane merge");
    slave = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule